// File: doc/BRIEF.md
# Receive Character Queue with Request Threshold

This block is a small first-in first-out store between a serial receiver and the processor or DMA engine that drains it. Each accepted character carries its eight data bits together with a parity-error flag and a framing-error flag. The oldest entry is always shown at the read port, so a reader sees the data and its flags before it pops them.

Two status outputs tell the reader that work is waiting. A character-available flag is high whenever anything is stored. A shared trigger drives both an interrupt request and a DMA read request, and each has its own enable. A mode input selects the trigger: in single mode it fires on any stored character, and in quad mode it fires only once at least four entries are held, so that the reader can take data in bursts.

If the receiver delivers a character while the store is full and nothing is read in that cycle, the new character replaces the newest stored entry. An overrun flag is then set, and it stays set until a clear pulse is given.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset, fill is 0 and char_avail, irq_req, dma_req and overrun are all low.
- R2: The read port shows the oldest stored entry: rd_data carries its data, rd_perr its parity-error flag and rd_ferr its framing-error flag. A cycle with rd_en high removes that entry, and entries leave in the order they were written.
- R3: char_avail is high exactly when fill is non-zero.
- R4: With quad_mode low, the trigger is true whenever fill is at least 1.
- R5: With quad_mode high, the trigger is true only when fill is at least 4.
- R6: irq_req equals the trigger ANDed with irq_en, and dma_req equals the trigger ANDed with dma_en. The two enables act independently.
- R7: A write while fill is 8 with rd_en low sets overrun. Fill stays 8 and the new character replaces the most recently stored entry.
- R8: overrun stays high until a cycle with ovr_clr high. If a new overrun event occurs in the same cycle as ovr_clr, overrun stays set.
- R9: A write and a read in the same cycle while full are both carried out. Fill stays 8 and overrun is not set.
- R10: A read while empty is ignored: fill stays 0 and no status changes.
- R11: The store holds 8 entries, and fill never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Character data |
| wr_perr | input | 1 | Parity-error flag of the character |
| wr_ferr | input | 1 | Framing-error flag of the character |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity-error flag of the oldest entry |
| rd_ferr | output | 1 | Framing-error flag of the oldest entry |
| quad_mode | input | 1 | 0: trigger on one entry, 1: trigger on four entries |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |
| char_avail | output | 1 | At least one entry stored |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA read request |
| overrun | output | 1 | Latched overrun flag |
| fill | output | 4 | Number of stored entries |

## Verification
Two functions can fall in the same cycle. A receiver write can arrive on a full store in the same cycle as a reader pop, and an overrun event can arrive in the same cycle as the clear pulse. The bench fills the store to eight and then drives each pair together. It judges the outcome by the overrun flag, by fill, and by draining the store to confirm which characters survived and in what order.

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 8,
  parameter int TRIG_LEVEL = 4,
  parameter int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_perr,
  input  logic              wr_ferr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  input  logic              quad_mode,
  input  logic              irq_en,
  input  logic              dma_en,
  input  logic              ovr_clr,
  output logic              char_avail,
  output logic              irq_req,
  output logic              dma_req,
  output logic              overrun,
  output logic [CNT_W-1:0]  fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DATA_W + 2;
  localparam logic [AW-1:0]    LAST  = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLV = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TRIGV = CNT_W'(TRIG_LEVEL);

  logic [EW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wptr, rptr, wptr_prev;
  logic [CNT_W-1:0] count;
  logic             full, empty, pop, push, clobber, hit;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == FULLV);
  assign empty     = (count == '0);
  assign pop       = rd_en && !empty;
  assign push      = wr_en && (!full || pop);
  assign clobber   = wr_en && full && !pop;
  assign wptr_prev = (wptr == '0) ? LAST : wptr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[wptr] <= {wr_perr, wr_ferr, wr_data};
    end else if (clobber) begin
      mem[wptr_prev] <= {wr_perr, wr_ferr, wr_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (clobber)      overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

  assign {rd_perr, rd_ferr, rd_data} = mem[rptr];
  assign hit        = quad_mode ? (count >= TRIGV) : !empty;
  assign char_avail = !empty;
  assign irq_req    = irq_en && hit;
  assign dma_req    = dma_en && hit;
  assign fill       = count;

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && fill == FULLV |=> overrun && fill == FULLV);

  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

  // R9
  full_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en && fill == FULLV && !overrun |=> !overrun && fill == FULLV);

  // R10
  empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && fill == '0 |=> fill == '0);

  // R11
  fill_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULLV);

  // R5
  quad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quad_mode && fill < TRIGV |-> !irq_req && !dma_req);

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_req);

  // R6
  dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);
endmodule

// File: tb/rx_char_fifo_test.sv
module rx_char_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_perr = 1'b0, wr_ferr = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       quad_mode = 1'b0, irq_en = 1'b1, dma_en = 1'b1, ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, char_avail, irq_req, dma_req, overrun;
  logic [3:0] fill;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_char_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .rd_en(rd_en), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .quad_mode(quad_mode),
    .irq_en(irq_en), .dma_en(dma_en), .ovr_clr(ovr_clr),
    .char_avail(char_avail), .irq_req(irq_req), .dma_req(dma_req),
    .overrun(overrun), .fill(fill)
  );

  // {wr, rd, mode, ie, de, pe, fe, data, fill, avail, irq, dma, pad}
  localparam logic [31:0] VEC [8] = '{
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'hA5,4'd1,1'b1,1'b1,1'b1,10'd0},
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h3C,4'd2,1'b1,1'b1,1'b1,10'd0},
    {1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,8'h81,4'd3,1'b1,1'b0,1'b0,10'd0},
    {1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h7E,4'd4,1'b1,1'b1,1'b1,10'd0},
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,4'd4,1'b1,1'b0,1'b1,10'd0},
    {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,4'd4,1'b1,1'b1,1'b0,10'd0},
    {1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,4'd3,1'b1,1'b0,1'b0,10'd0},
    {1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,4'd3,1'b1,1'b1,1'b1,10'd0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] d,
                     input logic pe, input logic fe, input logic clr);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d; wr_perr = pe; wr_ferr = fe; ovr_clr = clr;
    @(posedge clk);
    #2;
    wr_en = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    chk("R1 fill", 16'(fill), 16'd0);
    chk("R1 status", {12'd0, char_avail, irq_req, dma_req, overrun}, 16'd0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      quad_mode = VEC[i][29]; irq_en = VEC[i][28]; dma_en = VEC[i][27];
      cyc(VEC[i][31], VEC[i][30], VEC[i][24:17], VEC[i][26], VEC[i][25], 1'b0);
      // R3 R4 R5 R6 R11 table rows
      chk("R11 fill", 16'(fill), 16'(VEC[i][16:13]));
      chk("R3 avail", 16'(char_avail), 16'(VEC[i][12]));
      chk("R5 R4 R6 irq", 16'(irq_req), 16'(VEC[i][11]));
      chk("R6 dma", 16'(dma_req), 16'(VEC[i][10]));
    end

    // R2 order and flags: A5 was popped, 3C/pe, 81/fe, 7E remain
    chk("R2 head", {6'd0, rd_perr, rd_ferr, rd_data}, {6'd0, 1'b1, 1'b0, 8'h3C});
    cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R2 head", {6'd0, rd_perr, rd_ferr, rd_data}, {6'd0, 1'b0, 1'b1, 8'h81});
    cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R2 head", {6'd0, rd_perr, rd_ferr, rd_data}, {6'd0, 1'b0, 1'b0, 8'h7E});
    cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3 empty avail", 16'(char_avail), 16'd0);
    chk("R4 empty irq", 16'(irq_req), 16'd0);

    // R10 read on empty
    cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R10 fill", 16'(fill), 16'd0);
    chk("R10 status", {12'd0, char_avail, irq_req, dma_req, overrun}, 16'd0);

    // R11 fill to depth
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
    chk("R11 full", 16'(fill), 16'd8);
    chk("R11 no ovr", 16'(overrun), 16'd0);

    // R7 write while full
    cyc(1'b1, 1'b0, 8'hEE, 1'b0, 1'b0, 1'b0);
    chk("R7 ovr", 16'(overrun), 16'd1);
    chk("R7 fill", 16'(fill), 16'd8);

    // R8 overrun with clear in same cycle keeps flag
    cyc(1'b1, 1'b0, 8'hDD, 1'b1, 1'b0, 1'b1);
    chk("R8 set wins", 16'(overrun), 16'd1);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R8 hold", 16'(overrun), 16'd1);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R8 clear", 16'(overrun), 16'd0);

    // R9 read and write together while full
    cyc(1'b1, 1'b1, 8'h99, 1'b0, 1'b1, 1'b0);
    chk("R9 ovr", 16'(overrun), 16'd0);
    chk("R9 fill", 16'(fill), 16'd8);

    // R7 R9 drain: 41..46, DD/pe, 99/fe
    for (int i = 1; i < 7; i++) begin
      chk("R2 drain", {6'd0, rd_perr, rd_ferr, rd_data}, {8'd0, 8'h40 + 8'(i)});
      cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    end
    chk("R7 newest replaced", {6'd0, rd_perr, rd_ferr, rd_data}, {6'd0, 1'b1, 1'b0, 8'hDD});
    cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R9 accepted", {6'd0, rd_perr, rd_ferr, rd_data}, {6'd0, 1'b0, 1'b1, 8'h99});
    cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3 drained", 16'(fill), 16'd0);

    // R1 reset from a busy state
    cyc(1'b1, 1'b0, 8'h12, 1'b0, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    chk("R1 rereset", {8'd0, fill, char_avail, irq_req, dma_req, overrun}, 16'd0);

    finish_run();
  end
endmodule